// File: doc/BRIEF.md
# DMA Transfer Progress Flag Unit

This unit follows the progress of a single DMA channel through one transfer. When the channel enable rises, the unit captures the programmed item count. It then counts down one step for each item that completes. Two sticky status flags mark the transfer's progress: one at the midpoint and one at the end. A single interrupt line reports either flag, and each flag can be masked on its own.

Either side can decide when the transfer ends, and a flow-select input picks which. When the DMA side is in control, the transfer ends when the remaining count reaches zero. When the peripheral is in control, the transfer ends on a strobe from the peripheral. In that case the midpoint is unknown, so the half flag never sets. The flow selection is captured together with the count when the enable rises.

Top module: `dma_prog_flags`

## Requirements
- R1: After reset, `remaining`, `half_flag`, `full_flag` and `irq` are all 0.
- R2: On the first clock edge at which `ch_en` is 1 after being 0, `remaining` loads `prog_cnt`. The new value is visible in the cycle that follows.
- R3: While the transfer is active, each cycle with `item_done` = 1 lowers `remaining` by one. When no transfer is active (idle, disabled, or after the end), `item_done` has no effect and `remaining` holds its value.
- R4: With `flow_periph` = 0 (DMA in control), `half_flag` sets when the number of completed items equals `prog_cnt >> 1`, which rounds down for an odd count. It never sets when `prog_cnt >> 1` is 0.
- R5: With `flow_periph` = 1 (peripheral in control), `half_flag` stays 0 for the whole transfer.
- R6: With DMA in control, `full_flag` sets on the item that brings `remaining` from 1 to 0.
- R7: With the peripheral in control, `full_flag` sets on a `periph_end` pulse during the active transfer, and `remaining` shows the items still uncounted. With DMA in control, `periph_end` has no effect.
- R8: Both flags hold their value until their write-one clear strobe (`half_clr`, `full_clr`). When a set and a clear fall in the same cycle, the flag ends up set.
- R9: `irq` is 1 exactly when (`half_flag` and `half_ie`) or (`full_flag` and `full_ie`) holds, with no added delay.
- R10: The flow mode is captured from `flow_periph` at the enable rise. Changing `flow_periph` during a transfer does not change how that transfer behaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_en | input | 1 | Channel enable; a rising edge starts a transfer |
| prog_cnt | input | CW | Programmed number of items |
| flow_periph | input | 1 | 0: DMA ends the transfer; 1: the peripheral ends it |
| item_done | input | 1 | Strobe: one item has completed |
| periph_end | input | 1 | Strobe: the peripheral signals the end of the transfer |
| half_ie | input | 1 | Interrupt enable for the half flag |
| full_ie | input | 1 | Interrupt enable for the full flag |
| half_clr | input | 1 | Write-one clear for the half flag |
| full_clr | input | 1 | Write-one clear for the full flag |
| remaining | output | CW | Items still to transfer |
| half_flag | output | 1 | Sticky midpoint flag |
| full_flag | output | 1 | Sticky end-of-transfer flag |
| irq | output | 1 | Combined masked interrupt |

## Verification
The count, both flags and their clears each take effect one clock edge after the strobe that causes them. The interrupt follows flags and enables within the same cycle. The bench changes inputs on falling edges. It samples on the next falling edge, which puts the check half a cycle after the edge that registers the result. Interrupt-enable changes are checked a small delay after the enable is driven, with no clock edge between them. Midpoint cases cover an even count, an odd count, and a count of one. For these, the bench checks the flag one item before the expected midpoint and again on the item that reaches it.

// File: rtl/dpf_pkg.sv
package dpf_pkg;

  typedef enum logic {
    FLOW_DMA    = 1'b0,
    FLOW_PERIPH = 1'b1
  } flow_e;

  localparam int FLAG_HALF = 0;
  localparam int FLAG_FULL = 1;
  localparam int NFLAGS    = 2;

endpackage

// File: rtl/dpf_progress.sv
module dpf_progress
  import dpf_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ch_en,
  input  logic [CW-1:0] prog_cnt,
  input  logic          flow_sel,
  input  logic          item_done,
  input  logic          periph_end,
  output logic [CW-1:0] remaining,
  output logic          half_evt,
  output logic          end_evt
);

  localparam logic [CW-1:0] ONE = CW'(1);

  // midpoint of a transfer: floor(count / 2)
  function automatic logic [CW-1:0] mid_of(input logic [CW-1:0] c);
    return c >> 1;
  endfunction

  // one step down, never below zero
  function automatic logic [CW-1:0] dec_sat(input logic [CW-1:0] v);
    return (v == '0) ? v : v - ONE;
  endfunction

  logic          en_q;
  logic          active;
  logic          en_rise;
  logic          item_acc;
  flow_e         flow_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] done_q;
  logic [CW-1:0] mid_w;

  assign en_rise  = ch_en & ~en_q;
  assign item_acc = active & ch_en & item_done;
  assign mid_w    = mid_of(cnt_q);

  assign half_evt = item_acc && (flow_q == FLOW_DMA) && (mid_w != '0)
                    && ((done_q + ONE) == mid_w);

  assign end_evt  = active && ch_en &&
                    ((flow_q == FLOW_DMA) ? (item_acc && remaining == ONE)
                                          : periph_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      active    <= 1'b0;
      flow_q    <= FLOW_DMA;
      cnt_q     <= '0;
      done_q    <= '0;
      remaining <= '0;
    end else begin
      en_q <= ch_en;
      if (en_rise) begin
        remaining <= prog_cnt;
        cnt_q     <= prog_cnt;
        done_q    <= '0;
        flow_q    <= flow_e'(flow_sel);
        active    <= flow_sel | (prog_cnt != '0);
      end else begin
        if (!ch_en || end_evt) active <= 1'b0;
        if (item_acc) begin
          remaining <= dec_sat(remaining);
          done_q    <= done_q + ONE;
        end
      end
    end
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> remaining == $past(prog_cnt));

  p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (item_acc && !en_rise && remaining != '0) |=> remaining == $past(remaining) - ONE);

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !en_rise) |=> $stable(remaining));

  p_end_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> !active);

  p_no_mid_periph_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && flow_q == FLOW_PERIPH) |-> !half_evt);

endmodule

// File: rtl/dpf_sticky.sv
module dpf_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= set | (q & ~clr);
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (q && !clr) |=> q);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q);

endmodule

// File: rtl/dma_prog_flags.sv
module dma_prog_flags
  import dpf_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ch_en,
  input  logic [CW-1:0] prog_cnt,
  input  logic          flow_periph,
  input  logic          item_done,
  input  logic          periph_end,
  input  logic          half_ie,
  input  logic          full_ie,
  input  logic          half_clr,
  input  logic          full_clr,
  output logic [CW-1:0] remaining,
  output logic          half_flag,
  output logic          full_flag,
  output logic          irq
);

  logic              half_evt;
  logic              end_evt;
  logic [NFLAGS-1:0] set_v;
  logic [NFLAGS-1:0] clr_v;
  logic [NFLAGS-1:0] ie_v;
  logic [NFLAGS-1:0] q_v;

  dpf_progress #(.CW(CW)) u_progress (
    .clk        (clk),
    .rst_n      (rst_n),
    .ch_en      (ch_en),
    .prog_cnt   (prog_cnt),
    .flow_sel   (flow_periph),
    .item_done  (item_done),
    .periph_end (periph_end),
    .remaining  (remaining),
    .half_evt   (half_evt),
    .end_evt    (end_evt)
  );

  assign set_v[FLAG_HALF] = half_evt;
  assign set_v[FLAG_FULL] = end_evt;
  assign clr_v[FLAG_HALF] = half_clr;
  assign clr_v[FLAG_FULL] = full_clr;
  assign ie_v[FLAG_HALF]  = half_ie;
  assign ie_v[FLAG_FULL]  = full_ie;

  for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
    dpf_sticky u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (set_v[g]),
      .clr   (clr_v[g]),
      .q     (q_v[g])
    );
  end

  assign half_flag = q_v[FLAG_HALF];
  assign full_flag = q_v[FLAG_FULL];
  assign irq       = |(q_v & ie_v);

  p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (half_flag || full_flag));

  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!half_ie && !full_ie) |-> !irq);

  p_half_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(half_flag) |-> $past(item_done));

  p_full_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_flag) |-> $past(item_done || periph_end));

endmodule

// File: tb/dma_prog_flags_tb_top.sv
module dma_prog_flags_tb_top;

  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ch_en = 1'b0;
  logic [CW-1:0] prog_cnt = '0;
  logic          flow_periph = 1'b0;
  logic          item_done = 1'b0;
  logic          periph_end = 1'b0;
  logic          half_ie = 1'b0;
  logic          full_ie = 1'b0;
  logic          half_clr = 1'b0;
  logic          full_clr = 1'b0;
  logic [CW-1:0] remaining;
  logic          half_flag;
  logic          full_flag;
  logic          irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dma_prog_flags #(.CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .prog_cnt(prog_cnt),
    .flow_periph(flow_periph), .item_done(item_done), .periph_end(periph_end),
    .half_ie(half_ie), .full_ie(full_ie), .half_clr(half_clr), .full_clr(full_clr),
    .remaining(remaining), .half_flag(half_flag), .full_flag(full_flag), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic items(input int n);
    for (int i = 0; i < n; i++) begin
      item_done = 1'b1;
      @(negedge clk);
      item_done = 1'b0;
    end
  endtask

  task automatic pend();
    periph_end = 1'b1;
    @(negedge clk);
    periph_end = 1'b0;
  endtask

  task automatic start(input int cnt, input logic periph);
    ch_en = 1'b0; half_clr = 1'b1; full_clr = 1'b1;
    @(negedge clk);
    half_clr = 1'b0; full_clr = 1'b0;
    prog_cnt = CW'(cnt); flow_periph = periph; ch_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 remaining", int'(remaining), 0);
    chk("R1 half_flag", int'(half_flag), 0);
    chk("R1 full_flag", int'(full_flag), 0);
    chk("R1 irq", int'(irq), 0);
  endtask

  task automatic t_dma_even();
    start(6, 1'b0);
    chk("R2 load", int'(remaining), 6);
    items(2);
    chk("R4 half before midpoint", int'(half_flag), 0);
    items(1);
    chk("R4 half at midpoint 3 of 6", int'(half_flag), 1);
    chk("R3 decrement", int'(remaining), 3);
    items(2);
    chk("R6 full not yet", int'(full_flag), 0);
    items(1);
    chk("R6 full at zero", int'(full_flag), 1);
    chk("R6 remaining zero", int'(remaining), 0);
    items(2);
    chk("R3 items after end ignored", int'(remaining), 0);
  endtask

  task automatic t_odd_and_one();
    start(5, 1'b0);
    items(1);
    chk("R4 odd before midpoint", int'(half_flag), 0);
    items(1);
    chk("R4 odd midpoint rounds down", int'(half_flag), 1);
    start(1, 1'b0);
    items(1);
    chk("R4 count one no half", int'(half_flag), 0);
    chk("R6 count one full", int'(full_flag), 1);
  endtask

  task automatic t_periph();
    start(8, 1'b1);
    items(4);
    chk("R5 no half in periph mode", int'(half_flag), 0);
    chk("R7 no full before end strobe", int'(full_flag), 0);
    pend();
    chk("R7 full on end strobe", int'(full_flag), 1);
    chk("R7 remaining after end", int'(remaining), 4);
    chk("R5 half still zero", int'(half_flag), 0);
    start(4, 1'b0);
    pend();
    chk("R7 end strobe ignored in DMA mode", int'(full_flag), 0);
    chk("R7 remaining untouched", int'(remaining), 4);
  endtask

  task automatic t_flow_latch();
    start(4, 1'b1);
    flow_periph = 1'b0;
    items(2);
    chk("R10 mode held, no half", int'(half_flag), 0);
    items(2);
    chk("R10 mode held, no full at zero", int'(full_flag), 0);
    pend();
    chk("R10 periph end still honoured", int'(full_flag), 1);
  endtask

  task automatic t_sticky();
    repeat (3) @(negedge clk);
    chk("R8 full sticky", int'(full_flag), 1);
    full_clr = 1'b1;
    @(negedge clk);
    full_clr = 1'b0;
    chk("R8 clear", int'(full_flag), 0);
    start(2, 1'b0);
    items(1);
    chk("R8 half set count 2", int'(half_flag), 1);
    item_done = 1'b1; full_clr = 1'b1;
    @(negedge clk);
    item_done = 1'b0; full_clr = 1'b0;
    chk("R8 set wins over clear", int'(full_flag), 1);
  endtask

  task automatic t_irq();
    half_ie = 1'b0; full_ie = 1'b0; #1;
    chk("R9 masked", int'(irq), 0);
    half_ie = 1'b1; #1;
    chk("R9 half enabled", int'(irq), 1);
    @(negedge clk);
    half_clr = 1'b1;
    @(negedge clk);
    half_clr = 1'b0;
    chk("R9 half cleared", int'(irq), 0);
    full_ie = 1'b1; #1;
    chk("R9 full enabled", int'(irq), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_dma_even();
    t_odd_and_one();
    t_periph();
    t_flow_latch();
    t_sticky();
    t_irq();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule